// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a synchronous pipelined SRAM array. It takes in a start address and then gives the word address for each beat of a burst of four words. It registers the address when a qualified address strobe arrives. It then steps the two low address bits on every clock in which the advance input is low. The upper address bits stay fixed until the next qualified strobe. Each burst wraps within its four-word group.

Two address strobes can start an access. The processor strobe has priority over the controller strobe. The processor strobe is honoured only while the first chip enable is low. The controller strobe is not gated by that enable. If a strobe is acted on while the full chip-select condition is false, the block deselects. A static strap picks linear or interleaved beat order. Every pin is plain control or address. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `sel_valid` is 0 and `mem_addr` is 0.
- R2: On a clock edge where `strobe_cpu_n`=0, `en1_n`=0, `en2`=1 and `en3_n`=0, the block loads the address. After that edge `mem_addr` equals the sampled `addr_in` and `sel_valid` is 1.
- R3: When both strobes are low and `en1_n`=0, only the processor strobe is acted on. The result is exactly one load of `addr_in`, and the controller strobe has no further effect.
- R4: When `en1_n`=1, a low `strobe_cpu_n` is ignored. If `strobe_ctl_n` is high in that cycle, the edge behaves as if no strobe were present. An active burst still advances when `step_n`=0.
- R5: On a clock edge where `strobe_ctl_n`=0, `strobe_cpu_n`=1 and chip select is active (`en1_n`=0, `en2`=1, `en3_n`=0), the block loads `addr_in` and sets `sel_valid` to 1.
- R6: A strobe that is acted on while chip select is inactive clears `sel_valid` after that edge. This covers a controller strobe with any enable inactive. It also covers a processor strobe with `en1_n`=0 but `en2`=0 or `en3_n`=1.
- R7: With `order_sel`=0 (linear), beat k of a burst whose start low bits are s has low bits (s+k) mod 4. A start of 1 gives 1,2,3,0.
- R8: With `order_sel`=1 (interleaved), beat k has low bits s XOR k. A start of 2 gives 2,3,0,1, and a start of 1 gives 1,0,3,2.
- R9: The bits of `mem_addr` above the low two never change during a burst. The fifth beat returns to the start address.
- R10: While selected, an edge with no acted-on strobe and `step_n`=1 leaves `mem_addr` and `sel_valid` unchanged.
- R11: A qualified strobe in the middle of a burst restarts the sequence at the new `addr_in`. It takes priority over advancing.
- R12: While deselected, `step_n`=0 with no strobe leaves `mem_addr` unchanged and `sel_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | Start address, sampled on a qualified strobe |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, higher priority |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Advance input, active low |
| en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| order_sel | input | 1 | Static strap: 0 linear, 1 interleaved |
| mem_addr | output | AW | Current word address |
| sel_valid | output | 1 | Device selected and address valid |

## Verification
A corrupted beat counter or start register shows up in the low two bits of `mem_addr` on the very next edge that advances. A wrong upper register shows up as a changed high field during a burst, or as a fifth beat that misses its start. A wrong strobe arbitration shows up one edge after the strobe. It appears as a missed load, a spurious deselect, or a burst that fails to advance while the processor strobe is gated. Each of these effects is visible within one clock, so the checks sample every beat.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_LOAD  = 2'd1,
    EV_DESEL = 2'd2,
    EV_STEP  = 2'd3
  } burst_ev_e;
endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
  import burst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe_cpu_n,
  input  logic      strobe_ctl_n,
  input  logic      step_n,
  input  logic      en1_n,
  input  logic      en2,
  input  logic      en3_n,
  input  logic      selected,
  output burst_ev_e ev
);
  logic chip_sel, cpu_hit, ctl_hit;

  always_comb begin
    chip_sel = !en1_n && en2 && !en3_n;
    cpu_hit  = !strobe_cpu_n && !en1_n;
    ctl_hit  = !strobe_ctl_n && !cpu_hit;
    if (cpu_hit || ctl_hit)
      ev = chip_sel ? EV_LOAD : EV_DESEL;
    else if (!step_n && selected)
      ev = EV_STEP;
    else
      ev = EV_IDLE;
  end

  // R4: gated processor strobe alone never loads or deselects
  a_r4_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && en1_n && strobe_ctl_n) |-> (ev == EV_IDLE || ev == EV_STEP));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int LW = 2
) (
  input  logic [LW-1:0] start,
  input  logic [LW-1:0] count,
  input  logic          interleave,
  output logic [LW-1:0] low
);
  always_comb begin
    if (interleave) low = start ^ count;
    else            low = start + count;
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [LW-1:0] start_in,
  input  logic          interleave,
  output logic [LW-1:0] low_out
);
  localparam logic [LW-1:0] ONE = {{(LW-1){1'b0}}, 1'b1};
  logic [LW-1:0] start_q, cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      start_q <= start_in;
      cnt_q   <= '0;
    end else if (step) begin
      cnt_q   <= cnt_q + ONE;
    end
  end

  burst_order_map #(.LW(LW)) u_map (
    .start(start_q), .count(cnt_q), .interleave(interleave), .low(low_out)
  );

  // R7: linear order advances the low bits by one, modulo the group size
  a_r7_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !interleave && $stable(interleave)) |=> low_out == $past(low_out) + ONE);
  // R11: a load always restarts the burst at the sampled start bits
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (load && $stable(interleave)) |=> low_out == $past(start_in));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int AW = 20,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          strobe_cpu_n,
  input  logic          strobe_ctl_n,
  input  logic          step_n,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3_n,
  input  logic          order_sel,
  output logic [AW-1:0] mem_addr,
  output logic          sel_valid
);
  localparam int UW = AW - LW;

  burst_ev_e     ev;
  logic [UW-1:0] upper_q;
  logic [LW-1:0] low;
  logic          valid_q;

  burst_strobe_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .selected(valid_q), .ev(ev)
  );

  burst_beat_counter #(.LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(ev == EV_LOAD), .step(ev == EV_STEP),
    .start_in(addr_in[LW-1:0]), .interleave(order_sel), .low_out(low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      valid_q <= 1'b0;
    end else begin
      case (ev)
        EV_LOAD: begin
          upper_q <= addr_in[AW-1:LW];
          valid_q <= 1'b1;
        end
        EV_DESEL: valid_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign mem_addr  = {upper_q, low};
  assign sel_valid = valid_q;

  // R2: a qualified strobe puts the sampled address on the output
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_LOAD && $stable(order_sel)) |=> (sel_valid && mem_addr == $past(addr_in)));
  // R6: a strobe without chip select deselects
  a_r6_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_DESEL) |=> !sel_valid);
  // R10: no strobe and no advance holds the address
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_IDLE && $stable(order_sel)) |=> ($stable(mem_addr) && $stable(sel_valid)));
  // R9: stepping never disturbs the upper address field
  a_r9_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_STEP) |=> $stable(mem_addr[AW-1:LW]));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 20;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, step_n = 1'b1;
  logic en1_n = 1'b0, en2 = 1'b1, en3_n = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] mem_addr;
  logic sel_valid;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .order_sel(order_sel),
    .mem_addr(mem_addr), .sel_valid(sel_valid)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    strobe_cpu_n = 1; strobe_ctl_n = 1; step_n = 1;
    en1_n = 0; en2 = 1; en3_n = 0;
  endtask

  task automatic cpu_load(input logic [AW-1:0] a);
    idle(); addr_in = a; strobe_cpu_n = 0; tick(); idle();
  endtask

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] a, input int k, input bit il);
    logic [1:0] s = a[1:0];
    logic [1:0] kk = 2'(k);
    return {a[AW-1:2], il ? (s ^ kk) : 2'(s + kk)};
  endfunction

  task automatic t_reset();
    chk("R1 valid in reset", AW'(sel_valid), '0);
    chk("R1 addr in reset", mem_addr, '0);
    rst_n = 1; tick();
    chk("R1 valid after release", AW'(sel_valid), '0);
    chk("R1 addr after release", mem_addr, '0);
  endtask

  task automatic t_burst(input logic [AW-1:0] a, input bit il, input string req);
    idle(); order_sel = il;
    cpu_load(a);
    chk("R2 load addr", mem_addr, a);
    chk("R2 load valid", AW'(sel_valid), AW'(1));
    for (int k = 1; k <= 4; k++) begin
      step_n = 0; tick();
      chk(req, mem_addr, beat(a, k, il));
      chk("R9 upper field", mem_addr[AW-1:2], a[AW-1:2]);
    end
    chk("R9 fifth beat equals start", mem_addr, a);
    idle();
  endtask

  task automatic t_hold();
    order_sel = 0; cpu_load(20'h12341);
    step_n = 0; tick(); idle();
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10 hold addr", mem_addr, 20'h12342);
      chk("R10 hold valid", AW'(sel_valid), AW'(1));
    end
  endtask

  task automatic t_cpu_gated();
    order_sel = 0; cpu_load(20'h0AB00);
    en1_n = 1; strobe_cpu_n = 0; addr_in = 20'hFFFF3; step_n = 0; tick();
    chk("R4 gated cpu strobe steps", mem_addr, 20'h0AB01);
    chk("R4 gated cpu strobe keeps valid", AW'(sel_valid), AW'(1));
    step_n = 1; tick();
    chk("R4 gated cpu strobe no load", mem_addr, 20'h0AB01);
    idle();
  endtask

  task automatic t_priority();
    order_sel = 0; cpu_load(20'h00010);
    addr_in = 20'h55556; strobe_cpu_n = 0; strobe_ctl_n = 0; tick(); idle();
    chk("R3 both strobes one load", mem_addr, 20'h55556);
    chk("R3 valid", AW'(sel_valid), AW'(1));
  endtask

  task automatic t_ctl();
    order_sel = 1; idle();
    addr_in = 20'h3C3C1; strobe_ctl_n = 0; tick(); idle();
    chk("R5 ctl load addr", mem_addr, 20'h3C3C1);
    chk("R5 ctl load valid", AW'(sel_valid), AW'(1));
    step_n = 0; tick(); idle();
    chk("R8 ctl burst interleaved", mem_addr, 20'h3C3C0);
  endtask

  task automatic t_desel();
    order_sel = 0; cpu_load(20'h77770);
    en2 = 0; strobe_ctl_n = 0; tick(); idle();
    chk("R6 ctl desel", AW'(sel_valid), '0);
    cpu_load(20'h77771);
    en1_n = 1; strobe_ctl_n = 0; tick(); idle();
    chk("R6 ctl desel en1 high", AW'(sel_valid), '0);
    cpu_load(20'h77772);
    en3_n = 1; strobe_cpu_n = 0; tick(); idle();
    chk("R6 cpu desel en3", AW'(sel_valid), '0);
    step_n = 0; tick(); tick(); idle();
    chk("R12 no step while deselected addr", mem_addr, 20'h77772);
    chk("R12 still deselected", AW'(sel_valid), '0);
  endtask

  task automatic t_restart();
    order_sel = 0; cpu_load(20'h10002);
    step_n = 0; tick();
    addr_in = 20'h20003; strobe_cpu_n = 0; tick(); strobe_cpu_n = 1;
    chk("R11 restart addr", mem_addr, 20'h20003);
    tick(); idle();
    chk("R11 restart then linear", mem_addr, 20'h20000);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    t_burst(20'hABCD1, 0, "R7 linear start1");
    t_burst(20'h01232, 0, "R7 linear start2");
    t_burst(20'h45672, 1, "R8 interleaved start2");
    t_burst(20'h89AB1, 1, "R8 interleaved start1");
    t_hold();
    t_cpu_gated();
    t_priority();
    t_ctl();
    t_desel();
    t_restart();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule